// File: doc/BRIEF.md
# Four-Bit Port Unit with Bit-Addressable Output Latch

This block holds the port logic of a small nibble-wide controller. It serves one four-pin input port and one four-pin output port. The input pins can always be read back into the accumulator. Pin 0 and pins 1 to 3 can also be handed to a counter, an interrupt and a serial engine, which sit outside this block. The output port is driven from a latch. A whole-port load fills the latch from the accumulator. Single-bit set and clear operations change one latch bit and leave the others as they are.

The output enable is owned by a two-state machine. `ST_DARK` is entered on reset and keeps every pin released. The transition `DARK_TO_LIVE` fires on the first whole-port load and leads to `ST_LIVE`. `ST_LIVE` has one transition, `LIVE_HOLD`, back to itself, so only reset leaves it. Two static parameters fix the pin style, push-pull or open-drain, and whether pin 3 is given up to an oscillator resistor.

Top module: `quad_port_unit`

## Requirements
- R1: After reset every bit of `pin_oe` is 0 on both pin styles.
- R2: A set or clear issued before the first load changes the latch value seen on `pin_out` (push-pull), but `pin_oe` stays 0.
- R3: A load (`op_load`=1) copies `acc_in` into the latch. In the next cycle a push-pull port shows it on `pin_out` with `pin_oe`=1111.
- R4: A set or clear writes 1 or 0 into the latch bit addressed by `bit_idx` (0 = pin 0). The other three latched bits keep their values and are driven out as well.
- R5: When strobes coincide, load wins over set and set wins over clear. With no strobe the pin outputs hold their values.
- R6: While `op_read`=1, `rd_data` equals `pin_in`, whatever the mode inputs are. While `op_read`=0, `rd_data` is 0000.
- R7: `cnt_clk` follows `pin_in[0]` when `clk_mode`=01 and is 0 for every other code.
- R8: `int_test` follows `pin_in[0]` when `shift_mode[2]`=1 and is 0 otherwise.
- R9: `ser_en` is 1 when `shift_mode[1:0]` is not 00. Then `ser_lines` equals `pin_in[3:1]`; otherwise it is 000.
- R10: With open-drain style, `pin_out` is 0 and a live pin is enabled only where its latch bit is 0.
- R11: With pin 3 reserved, `pin_oe[3]` and `pin_out[3]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_in | input | 4 | Accumulator value for a load |
| op_load | input | 1 | Whole-port load strobe |
| op_set | input | 1 | Single-bit set strobe |
| op_clr | input | 1 | Single-bit clear strobe |
| op_read | input | 1 | Input-port read strobe |
| bit_idx | input | 2 | Latch bit addressed by set or clear |
| clk_mode | input | 2 | Clock-mode bits; 01 routes pin 0 to the counter |
| shift_mode | input | 3 | Bit 2 routes pin 0 to the interrupt; bits 1:0 enable serial |
| pin_in | input | 4 | Input pin levels |
| rd_data | output | 4 | Read data to the accumulator |
| cnt_clk | output | 1 | Routed counter clock |
| int_test | output | 1 | Routed testable interrupt |
| ser_en | output | 1 | Serial engine owns pins 1 to 3 |
| ser_lines | output | 3 | Routed pins 3:1 for the serial engine |
| pin_out | output | 4 | Output pin value |
| pin_oe | output | 4 | Output pin enable |

## Verification
The bench sets and clears bits before the first load. A design that enables the pins early would drive levels nobody chose, and this shows up as a nonzero `pin_oe`. It fires all three strobes together and pairs set with clear on one bit. A wrong priority order leaves a latch value the load did not ask for. Reads are repeated under every routing code: a design that gates the read path by mode returns zeros. A second instance uses open-drain style with pin 3 reserved. A design that inverts the wrong way, or drives pin 3, shows a wrong enable pattern there.

// File: rtl/qpu_pkg.sv
package qpu_pkg;
    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } port_op_e;

    typedef enum logic {
        ST_DARK,
        ST_LIVE
    } drive_st_e;
endpackage

// File: rtl/qpu_op_decode.sv
module qpu_op_decode
    import qpu_pkg::*;
(
    input  logic     op_load,
    input  logic     op_set,
    input  logic     op_clr,
    output port_op_e op
);
    always_comb begin
        if (op_load)     op = OP_LOAD;
        else if (op_set) op = OP_SET;
        else if (op_clr) op = OP_CLR;
        else             op = OP_NONE;
    end
endmodule

// File: rtl/qpu_out_latch.sv
module qpu_out_latch
    import qpu_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_e          op,
    input  logic [PORT_W-1:0] acc_in,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [PORT_W-1:0] latch_q,
    output logic              live
);
    drive_st_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DARK;
        else        state_q <= state_d;
    end

    // transitions: DARK_TO_LIVE on first load, LIVE_HOLD otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DARK: if (op == OP_LOAD) state_d = ST_LIVE;
            ST_LIVE: state_d = ST_LIVE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        unique case (state_q)
            ST_DARK: live = 1'b0;
            ST_LIVE: live = 1'b1;
        endcase
    end

    // latch storage, written in either state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: latch_q <= acc_in;
                OP_SET:  latch_q[bit_idx] <= 1'b1;
                OP_CLR:  latch_q[bit_idx] <= 1'b0;
                OP_NONE: latch_q <= latch_q;
            endcase
        end
    end
endmodule

// File: rtl/qpu_pad_drive.sv
module qpu_pad_drive #(
    parameter int PORT_W        = 4,
    parameter bit OPEN_DRAIN    = 1'b0,
    parameter bit PIN3_RESERVED = 1'b0
) (
    input  logic [PORT_W-1:0] latch_q,
    input  logic              live,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    localparam int RSV_PIN = PORT_W - 1;

    for (genvar g = 0; g < PORT_W; g++) begin : g_pin
        if (PIN3_RESERVED && g == RSV_PIN) begin : g_rsv
            assign pin_out[g] = 1'b0;
            assign pin_oe[g]  = 1'b0;
        end else if (OPEN_DRAIN) begin : g_od
            assign pin_out[g] = 1'b0;
            assign pin_oe[g]  = live & ~latch_q[g];
        end else begin : g_pp
            assign pin_out[g] = latch_q[g];
            assign pin_oe[g]  = live;
        end
    end
endmodule

// File: rtl/qpu_in_route.sv
module qpu_in_route #(
    parameter int PORT_W = 4
) (
    input  logic [PORT_W-1:0] pin_in,
    input  logic              op_read,
    input  logic [1:0]        clk_mode,
    input  logic [2:0]        shift_mode,
    output logic [PORT_W-1:0] rd_data,
    output logic              cnt_clk,
    output logic              int_test,
    output logic              ser_en,
    output logic [PORT_W-2:0] ser_lines
);
    localparam logic [1:0] CM_EXT_COUNT = 2'b01;

    always_comb begin
        rd_data   = op_read ? pin_in : '0;
        cnt_clk   = (clk_mode == CM_EXT_COUNT) & pin_in[0];
        int_test  = shift_mode[2] & pin_in[0];
        ser_en    = |shift_mode[1:0];
        ser_lines = ser_en ? pin_in[PORT_W-1:1] : '0;
    end
endmodule

// File: rtl/quad_port_unit.sv
module quad_port_unit
    import qpu_pkg::*;
#(
    parameter int PORT_W        = 4,
    parameter bit OPEN_DRAIN    = 1'b0,
    parameter bit PIN3_RESERVED = 1'b0,
    localparam int IDX_W        = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] acc_in,
    input  logic              op_load,
    input  logic              op_set,
    input  logic              op_clr,
    input  logic              op_read,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [1:0]        clk_mode,
    input  logic [2:0]        shift_mode,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] rd_data,
    output logic              cnt_clk,
    output logic              int_test,
    output logic              ser_en,
    output logic [PORT_W-2:0] ser_lines,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    port_op_e          op;
    logic [PORT_W-1:0] latch_q;
    logic              live;

    qpu_op_decode u_dec (
        .op_load (op_load),
        .op_set  (op_set),
        .op_clr  (op_clr),
        .op      (op)
    );

    qpu_out_latch #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .acc_in  (acc_in),
        .bit_idx (bit_idx),
        .latch_q (latch_q),
        .live    (live)
    );

    qpu_pad_drive #(
        .PORT_W(PORT_W), .OPEN_DRAIN(OPEN_DRAIN), .PIN3_RESERVED(PIN3_RESERVED)
    ) u_pad (
        .latch_q (latch_q),
        .live    (live),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    qpu_in_route #(.PORT_W(PORT_W)) u_route (
        .pin_in     (pin_in),
        .op_read    (op_read),
        .clk_mode   (clk_mode),
        .shift_mode (shift_mode),
        .rd_data    (rd_data),
        .cnt_clk    (cnt_clk),
        .int_test   (int_test),
        .ser_en     (ser_en),
        .ser_lines  (ser_lines)
    );
endmodule

// File: rtl/qpu_checker.sv
module qpu_checker #(
    parameter int PORT_W        = 4,
    parameter bit OPEN_DRAIN    = 1'b0,
    parameter bit PIN3_RESERVED = 1'b0,
    parameter int IDX_W         = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_load,
    input logic              op_set,
    input logic              op_clr,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [PORT_W-1:0] acc_in,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe
);
    localparam int              RSV_PIN = PORT_W - 1;
    localparam logic [PORT_W-1:0] MASK =
        PIN3_RESERVED ? ~(PORT_W'(1) << RSV_PIN) : '1;

    logic seen_load;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_load <= 1'b0;
        else if (op_load) seen_load <= 1'b1;
    end

    assert_dark_until_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe != '0) |-> seen_load);

    assert_load_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!OPEN_DRAIN && op_load) |=> (pin_out == ($past(acc_in) & MASK)) && (pin_oe == MASK));

    assert_set_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!OPEN_DRAIN && op_set && !op_load &&
         !(PIN3_RESERVED && bit_idx == IDX_W'(RSV_PIN))) |=> pin_out[$past(bit_idx)]);

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_load && !op_set && !op_clr) |=> $stable(pin_out));

    assert_od_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (OPEN_DRAIN && op_load) |=> pin_oe == (~$past(acc_in) & MASK));

    assert_rsv_pin_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        PIN3_RESERVED |-> (pin_oe[RSV_PIN] == 1'b0));
endmodule

bind quad_port_unit qpu_checker #(
    .PORT_W(PORT_W), .OPEN_DRAIN(OPEN_DRAIN),
    .PIN3_RESERVED(PIN3_RESERVED), .IDX_W(IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_load (op_load),
    .op_set  (op_set),
    .op_clr  (op_clr),
    .bit_idx (bit_idx),
    .acc_in  (acc_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/quad_port_unit_tb.sv
`timescale 1ns/1ps
module quad_port_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] acc_in = '0;
    logic       op_load = 0, op_set = 0, op_clr = 0, op_read = 0;
    logic [1:0] bit_idx = '0;
    logic [1:0] clk_mode = '0;
    logic [2:0] shift_mode = '0;
    logic [3:0] pin_in = '0;
    logic [3:0] rd_data, pin_out, pin_oe, od_out, od_oe, od_rd;
    logic       cnt_clk, int_test, ser_en, od_cnt, od_int, od_ser;
    logic [2:0] ser_lines, od_lines;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    quad_port_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .op_load(op_load),
        .op_set(op_set), .op_clr(op_clr), .op_read(op_read), .bit_idx(bit_idx),
        .clk_mode(clk_mode), .shift_mode(shift_mode), .pin_in(pin_in),
        .rd_data(rd_data), .cnt_clk(cnt_clk), .int_test(int_test),
        .ser_en(ser_en), .ser_lines(ser_lines), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    quad_port_unit #(.OPEN_DRAIN(1'b1), .PIN3_RESERVED(1'b1)) u_od (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .op_load(op_load),
        .op_set(op_set), .op_clr(op_clr), .op_read(op_read), .bit_idx(bit_idx),
        .clk_mode(clk_mode), .shift_mode(shift_mode), .pin_in(pin_in),
        .rd_data(od_rd), .cnt_clk(od_cnt), .int_test(od_int),
        .ser_en(od_ser), .ser_lines(od_lines), .pin_out(od_out), .pin_oe(od_oe)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // apply strobes for one edge, then look one edge later
    task automatic pulse(logic ld, logic st, logic cl, logic [1:0] idx, logic [3:0] acc);
        @(negedge clk);
        op_load = ld; op_set = st; op_clr = cl; bit_idx = idx; acc_in = acc;
        @(negedge clk);
        op_load = 0; op_set = 0; op_clr = 0;
    endtask

    task automatic t_reset;
        chk("R1 pp oe", {4'h0, pin_oe}, 8'h00);
        chk("R1 od oe", {4'h0, od_oe}, 8'h00);
    endtask

    task automatic t_early_bits;
        pulse(0, 1, 0, 2'd2, 4'h0);
        chk("R2 latch set", {4'h0, pin_out}, 8'h04);
        chk("R2 oe dark", {4'h0, pin_oe}, 8'h00);
        pulse(0, 0, 1, 2'd2, 4'h0);
        chk("R2 latch clr", {4'h0, pin_out}, 8'h00);
        chk("R2 od oe dark", {4'h0, od_oe}, 8'h00);
    endtask

    task automatic t_load;
        pulse(1, 0, 0, 2'd0, 4'hA);
        chk("R3 out", {4'h0, pin_out}, 8'h0A);
        chk("R3 oe", {4'h0, pin_oe}, 8'h0F);
        chk("R10 od oe", {4'h0, od_oe}, 8'h05);
        chk("R10 od out", {4'h0, od_out}, 8'h00);
    endtask

    task automatic t_bits;
        pulse(0, 1, 0, 2'd0, 4'h0);
        chk("R4 set0", {4'h0, pin_out}, 8'h0B);
        pulse(0, 0, 1, 2'd3, 4'h0);
        chk("R4 clr3", {4'h0, pin_out}, 8'h03);
        chk("R4 oe live", {4'h0, pin_oe}, 8'h0F);
        pulse(0, 1, 0, 2'd3, 4'h0);
        chk("R4 set3", {4'h0, pin_out}, 8'h0B);
        chk("R11 od oe", {4'h0, od_oe}, 8'h04);
        chk("R11 od out", {4'h0, od_out}, 8'h00);
    endtask

    task automatic t_priority;
        pulse(1, 1, 1, 2'd0, 4'h6);
        chk("R5 load wins", {4'h0, pin_out}, 8'h06);
        pulse(0, 1, 1, 2'd0, 4'h0);
        chk("R5 set over clr", {4'h0, pin_out}, 8'h07);
        pulse(0, 0, 0, 2'd1, 4'h9);
        chk("R5 idle hold", {4'h0, pin_out}, 8'h07);
        pulse(0, 0, 1, 2'd1, 4'h0);
        chk("R5 clr only", {4'h0, pin_out}, 8'h05);
    endtask

    task automatic t_read;
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            pin_in = 4'h9; op_read = 1; clk_mode = m[1:0]; shift_mode = m[2:0];
            #1 chk("R6 read", {4'h0, rd_data}, 8'h09);
        end
        op_read = 0;
        #1 chk("R6 idle zero", {4'h0, rd_data}, 8'h00);
        clk_mode = 0; shift_mode = 0;
    endtask

    task automatic t_route;
        @(negedge clk);
        pin_in = 4'h1; clk_mode = 2'b01;
        #1 chk("R7 count on", {7'h0, cnt_clk}, 8'h01);
        clk_mode = 2'b10;
        #1 chk("R7 count off", {7'h0, cnt_clk}, 8'h00);
        shift_mode = 3'b100;
        #1 chk("R8 int on", {7'h0, int_test}, 8'h01);
        chk("R9 serial off", {4'h0, ser_en, ser_lines}, 8'h00);
        shift_mode = 3'b011; pin_in = 4'hE;
        #1 chk("R9 serial on", {4'h0, ser_en, ser_lines}, 8'h0F);
        chk("R8 int off", {7'h0, int_test}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_early_bits();
        t_load();
        t_bits();
        t_priority();
        t_read();
        t_route();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule